// File: doc/BRIEF.md
# Serial Divider Configuration Register

This block takes divider settings for a clock-translation PLL over a three-wire serial link: a serial clock, a serial data line and a load strobe. It holds the settings in two registered outputs, a 6-bit feedback divider value and a 2-bit output divider code. All three serial lines are brought into the system clock domain through synchronizer chains. The block works on the synchronized edges of the serial clock and the strobe.

Bits go into a shift register on each rising serial clock edge. The latch stage that follows has three behaviours, selected by the strobe. When the strobe rises, the latch copies the shift register. While the strobe is low, the latch keeps its value. While the strobe is high, the latch follows every new bit as it is shifted in. A hard-wired select input gives the output divider code its start-up value, so the PLL runs with usable dividers before any serial traffic arrives.

Top module: `ser_div_cfg`

## Requirements
- R1: While `rst` is high at a `clk` edge, `m_div` becomes 32 and `n_code` becomes {0, `pu_nsel`}, and the shift register is cleared to all zeros.
- R2: Each rising synchronized `ser_clk` edge shifts one `ser_dat` bit into the shift register. Falling edges do nothing. While `ser_ld` is low, this shifting leaves `m_div` and `n_code` unchanged.
- R3: A frame is 14 bits, sent first to last. Bits 1 and 2 are low lead bits, bit 3 is unused, bits 4 and 5 are N1 and N0, bits 6 to 8 are unused, and bits 9 to 14 are M5 down to M0. On a rising `ser_ld`, `m_div` takes M and `n_code` takes {N1, N0}.
- R4: After `ser_ld` falls, `m_div` and `n_code` stay frozen while further frames are shifted, until the next rising `ser_ld`.
- R5: While `ser_ld` is held high, each rising `ser_clk` edge shifts the bit in and updates `m_div` and `n_code` from the shifted contents.
- R6: The lead bits and unused bits of a frame have no effect on the latched values.
- R7: When the latched M value is below 4, `m_div` is set to 4. `m_div` is never below 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Load strobe: low shifts, rising copies, high passes through |
| pu_nsel | input | 1 | Hard-wired start-up select for the output divider code |
| m_div | output | 6 | Latched feedback divider value |
| n_code | output | 2 | Latched output divider code (0 = divide by 1, 1 = divide by 4) |

## Verification
The bench goes after the edges between strobe modes. One check raises the strobe right after reset with nothing shifted in; a design that did not clear its shift register would latch stale bits. Frames shifted after the strobe falls must not reach the outputs; a latch left transparent would follow them. In pass-through mode, every single bit must update the outputs; a design that only copied on the strobe edge would sit still. Frames with the lead and unused bits set to one test field placement, and M values 0 to 5 test the clamp boundary.

// File: rtl/ser_div_cfg_pkg.sv
package ser_div_cfg_pkg;
  typedef enum logic [1:0] {
    LAT_HOLD = 2'd0,
    LAT_LOAD = 2'd1,
    LAT_PASS = 2'd2
  } lat_mode_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= chain[STAGES-1];
  end

  assign q    = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int M_W   = 6,
  parameter int N_W   = 2,
  parameter int N_LSB = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           din,
  output logic [M_W-1:0] cur_m,
  output logic [N_W-1:0] cur_n,
  output logic [M_W-1:0] nxt_m,
  output logic [N_W-1:0] nxt_n
);
  localparam int SR_W = N_LSB + N_W;
  logic [SR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (shift_en) sr <= {sr[SR_W-2:0], din};
  end

  assign cur_m = sr[M_W-1:0];
  assign cur_n = sr[N_LSB +: N_W];
  assign nxt_m = {sr[M_W-2:0], din};
  assign nxt_n = sr[N_LSB-1 +: N_W];
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import ser_div_cfg_pkg::*;
#(
  parameter int M_W       = 6,
  parameter int N_W       = 2,
  parameter int M_MIN     = 4,
  parameter int M_DEFAULT = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pu_nsel,
  input  lat_mode_e      mode,
  input  logic [M_W-1:0] ld_m,
  input  logic [N_W-1:0] ld_n,
  input  logic [M_W-1:0] ps_m,
  input  logic [N_W-1:0] ps_n,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out
);
  localparam logic [M_W-1:0] MIN_V = M_W'(M_MIN);
  localparam logic [M_W-1:0] DEF_V = M_W'(M_DEFAULT);

  logic [M_W-1:0] m_sel;
  logic [N_W-1:0] n_sel;

  always_comb begin
    m_sel = (mode == LAT_PASS) ? ps_m : ld_m;
    n_sel = (mode == LAT_PASS) ? ps_n : ld_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_out <= DEF_V;
      n_out <= {{(N_W-1){1'b0}}, pu_nsel};
    end else if (mode != LAT_HOLD) begin
      m_out <= (m_sel < MIN_V) ? MIN_V : m_sel;
      n_out <= n_sel;
    end
  end
endmodule

// File: rtl/ser_div_cfg.sv
module ser_div_cfg
  import ser_div_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_W         = 6,
  parameter int N_W         = 2,
  parameter int N_LSB       = 9,
  parameter int M_MIN       = 4,
  parameter int M_DEFAULT   = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  input  logic           pu_nsel,
  output logic [M_W-1:0] m_div,
  output logic [N_W-1:0] n_code
);
  logic [2:0] s_lvl, s_rise;
  logic       clk_rise, ld_rise, ld_hi, dat_s, pass_evt;
  lat_mode_e  mode;
  logic [M_W-1:0] cur_m, nxt_m;
  logic [N_W-1:0] cur_n, nxt_n;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({ser_ld, ser_dat, ser_clk}),
    .q(s_lvl), .rise(s_rise)
  );

  assign clk_rise = s_rise[0];
  assign ld_rise  = s_rise[2];
  assign dat_s    = s_lvl[1];
  assign ld_hi    = s_lvl[2];
  assign pass_evt = ld_hi & clk_rise & ~ld_rise;

  always_comb begin
    if (ld_rise)       mode = LAT_LOAD;
    else if (pass_evt) mode = LAT_PASS;
    else               mode = LAT_HOLD;
  end

  cfg_shift #(.M_W(M_W), .N_W(N_W), .N_LSB(N_LSB)) u_shift (
    .clk(clk), .rst(rst), .shift_en(clk_rise), .din(dat_s),
    .cur_m(cur_m), .cur_n(cur_n), .nxt_m(nxt_m), .nxt_n(nxt_n)
  );

  cfg_latch #(.M_W(M_W), .N_W(N_W), .M_MIN(M_MIN), .M_DEFAULT(M_DEFAULT)) u_latch (
    .clk(clk), .rst(rst), .pu_nsel(pu_nsel), .mode(mode),
    .ld_m(cur_m), .ld_n(cur_n), .ps_m(nxt_m), .ps_n(nxt_n),
    .m_out(m_div), .n_out(n_code)
  );
endmodule

// File: rtl/ser_div_cfg_chk.sv
module ser_div_cfg_chk #(
  parameter int M_W       = 6,
  parameter int N_W       = 2,
  parameter int M_MIN     = 4,
  parameter int M_DEFAULT = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           pu_nsel,
  input logic           ld_rise,
  input logic           pass_evt,
  input logic [M_W-1:0] cur_m,
  input logic [N_W-1:0] cur_n,
  input logic [M_W-1:0] nxt_m,
  input logic [N_W-1:0] nxt_n,
  input logic [M_W-1:0] m_div,
  input logic [N_W-1:0] n_code
);
  localparam logic [M_W-1:0] MIN_V = M_W'(M_MIN);

  assert_reset_default_R1: assert property (@(posedge clk)
    rst |=> (m_div == M_W'(M_DEFAULT)) && (n_code == {{(N_W-1){1'b0}}, $past(pu_nsel)}));

  assert_load_copy_R3: assert property (@(posedge clk) disable iff (rst)
    ld_rise |=> (n_code == $past(cur_n)) &&
                (m_div == (($past(cur_m) < MIN_V) ? MIN_V : $past(cur_m))));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld_rise && !pass_evt) |=> ($stable(m_div) && $stable(n_code)));

  assert_pass_through_R5: assert property (@(posedge clk) disable iff (rst)
    pass_evt |=> (n_code == $past(nxt_n)) &&
                 (m_div == (($past(nxt_m) < MIN_V) ? MIN_V : $past(nxt_m))));

  assert_min_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    m_div >= MIN_V);
endmodule

bind ser_div_cfg ser_div_cfg_chk #(
  .M_W(M_W), .N_W(N_W), .M_MIN(M_MIN), .M_DEFAULT(M_DEFAULT)
) u_chk (
  .clk(clk), .rst(rst), .pu_nsel(pu_nsel), .ld_rise(ld_rise), .pass_evt(pass_evt),
  .cur_m(cur_m), .cur_n(cur_n), .nxt_m(nxt_m), .nxt_n(nxt_n),
  .m_div(m_div), .n_code(n_code)
);

// File: tb/ser_div_cfg_tb.sv
module ser_div_cfg_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, ser_clk, ser_dat, ser_ld, pu_nsel;
  logic [5:0] m_div;
  logic [1:0] n_code;

  ser_div_cfg u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld(ser_ld), .pu_nsel(pu_nsel), .m_div(m_div), .n_code(n_code)
  );

  typedef struct {
    logic [5:0] m;
    logic [1:0] n;
    string      tag;
  } exp_t;

  exp_t        exp_q[$];
  exp_t        held;
  logic [10:0] model;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  // Monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin : mon
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_chk++;
      if (m_div !== e.m || n_code !== e.n) begin
        n_fail++;
        $display("FAIL %s: m_div=%0d n_code=%0d expected m_div=%0d n_code=%0d",
                 e.tag, m_div, n_code, e.m, e.n);
      end
    end
  end

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    e = held;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic take_model();
    held.m = (model[5:0] < 6'd4) ? 6'd4 : model[5:0];
    held.n = model[10:9];
  endtask

  task automatic do_reset(input logic pu);
    rst = 1'b1; pu_nsel = pu;
    ser_clk = 1'b0; ser_dat = 1'b0; ser_ld = 1'b0;
    wait_n(4);
    rst = 1'b0;
    model = '0;
    held.m = 6'd32;
    held.n = {1'b0, pu};
    wait_n(4);
    expect_now("R1 reset defaults");
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b;  wait_n(4);
    ser_clk = 1'b1; wait_n(4);
    ser_clk = 1'b0; wait_n(4);
    model = {model[9:0], b};
    if (ser_ld) take_model();
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) shift_bit(f[i]);
  endtask

  function automatic logic [13:0] mk_frame(input logic [1:0] n, input logic [5:0] m,
                                          input logic [5:0] junk);
    return {junk[5:4], junk[0], n[1], n[0], junk[3:1], m};
  endfunction

  task automatic strobe_up();
    ser_ld = 1'b1; wait_n(6);
    take_model();
  endtask

  task automatic strobe_down();
    ser_ld = 1'b0; wait_n(6);
  endtask

  initial begin
    held = '{m: 6'd0, n: 2'd0, tag: ""};
    model = '0;
    do_reset(1'b1);

    // R1 R7: cleared shift register gives M=0 (clamped to 4) and N=0
    strobe_up();
    expect_now("R1 R7 load of cleared register");
    strobe_down();
    expect_now("R4 value kept after strobe falls");

    // R2 R3 R4: random frames
    for (int k = 0; k < 8; k++) begin
      send_frame(mk_frame(2'($urandom), 6'($urandom), 6'd0));
      expect_now("R2 R4 unchanged while shifting");
      strobe_up();
      expect_now("R3 load on rising strobe");
      strobe_down();
    end

    // R6: lead and unused bits all ones
    send_frame(mk_frame(2'b01, 6'd45, 6'h3F));
    strobe_up();
    expect_now("R6 lead/unused bits set");
    strobe_down();
    send_frame(mk_frame(2'b10, 6'd17, 6'h2A));
    strobe_up();
    expect_now("R6 mixed unused bits");
    strobe_down();

    // R7: clamp boundary
    for (int mv = 0; mv < 6; mv++) begin
      send_frame(mk_frame(2'b11, 6'(mv), 6'd0));
      strobe_up();
      expect_now("R7 clamp boundary");
      strobe_down();
    end

    // R5: pass-through while strobe high
    strobe_up();
    expect_now("R3 load before pass-through");
    for (int k = 0; k < 9; k++) begin
      shift_bit(1'($urandom));
      expect_now("R5 pass-through per bit");
    end
    strobe_down();
    for (int k = 0; k < 6; k++) shift_bit(1'($urandom));
    expect_now("R4 frozen after pass-through ends");

    do_reset(1'b0);

    wait_n(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule